// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block lets a clocked host read and write an external 128K x 8 asynchronous static RAM. The memory has two chip selects of opposite polarity: it is selected only while the active-low select is low and the active-high select is high. The host issues one access at a time through a valid/ready request channel. Each access produces a one-cycle response pulse, and a read's response also carries the read data. Strobe widths are whole clock cycles, derived at elaboration from nanosecond timing parameters and a clock-period parameter, always rounding up. When a per-phase minimum and a whole-cycle minimum disagree, the larger one wins.

Request back-pressure works like this. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only when the controller is idle, no retention request is pending, and no read turnaround is blocking a write. The response has no back-pressure: `rsp_valid` pulses for one cycle and the host must take it then.

A power-loss retention input makes the controller deselect the memory. It finishes any access already in flight before it does so. Once the input drops, the controller waits out a recovery hold-off before it accepts requests again.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and right after reset, the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0, and `req_ready`=1.
- R2: Every request accepted on `req_valid && req_ready` yields exactly one `rsp_valid` pulse, one cycle long. Responses come back in acceptance order.
- R3: A write holds `mem_we_n` low for exactly WLOW cycles, the maximum of ceil(write pulse), ceil(address-to-end), ceil(select-to-end) and ceil(data setup). At the defaults with a 10 ns clock this is 6. Next come WREC cycles (at least 1) with WE high, select still active and the address unchanged. The address stays stable while the memory is selected.
- R4: `mem_dq_oe` is high only while WE is low and the memory is selected. During that time `mem_dq_o` carries the accepted write data.
- R5: A read holds the select active, `mem_oe_n` low and `mem_we_n` high for exactly RLEN cycles, the maximum of ceil(cycle), ceil(address access) and ceil(OE access); this is 7 at the defaults. `mem_dq_i` is captured on the last of those cycles and returned in `rsp_rdata`.
- R6: OE and WE are never low together, and the controller never drives the data bus while OE is low.
- R7: After a read completes, no write starts until the outputs have had ceil(output float) cycles, at least 1 (3 at defaults). The WE falling edge comes at least 4 cycles after the read's response cycle. A read may follow a read with no gap.
- R8: Between accesses the memory is deselected, with OE and WE high.
- R9: A high `ret_req` drops `req_ready` at once. An access in flight still completes and responds. After that the memory is deselected from the next cycle on, and stored data is kept.
- R10: After `ret_req` falls, `req_ready` stays low for ceil(recovery time) cycles plus one, then rises.
- R11: `rsp_rdata` holds the last read value until another read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Data of the last completed read |
| ret_req | input | 1 | Retention request (level) |
| mem_addr | output | 17 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_i | input | 8 | Data from memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
Some rules hold on every cycle, and the embedded properties check them continuously:
- the bus never has two drivers;
- OE and WE are never low together;
- the address holds while the memory is selected;
- the response is a single-cycle pulse;
- retention deselects the memory and blocks acceptance.

Other behaviour only shows up across a scenario, so the bench scenarios cover it:
- exact strobe widths;
- read data returned in order;
- the read-to-write turnaround gap;
- the recovery hold-off length;
- data surviving a retention episode.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_ACT,
    ST_WR_REC,
    ST_RD,
    ST_RET,
    ST_RECOV
  } ctrl_state_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrl_state_t st,
  output logic        cs1_n,
  output logic        cs2,
  output logic        oe_n,
  output logic        we_n,
  output logic        dq_oe
);
  logic sel;

  always_comb begin
    sel   = (st == ST_WR_ACT) || (st == ST_WR_REC) || (st == ST_RD);
    cs1_n = !sel;
    cs2   = sel;
    oe_n  = (st != ST_RD);
    we_n  = (st != ST_WR_ACT);
    dq_oe = (st == ST_WR_ACT);
  end

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n) && !(!oe_n && !we_n));

  // R4
  drive_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cs1_n && cs2 && !we_n));
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS  = 50,
  parameter int T_WC_NS  = 70,
  parameter int T_AW_NS  = 60,
  parameter int T_CW_NS  = 60,
  parameter int T_DW_NS  = 30,
  parameter int T_WR_NS  = 5,
  parameter int T_RC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_OHZ_NS = 30,
  parameter int T_REC_NS = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int WLOW = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                             imax(imax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)), 1));
  localparam int WREC = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS) - WLOW));
  localparam int RLEN = imax(1, imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                     ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int TA   = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
  localparam int RECC = imax(1, ns_to_cyc(T_REC_NS, CLK_NS));
  localparam int PH_W = $clog2(imax(WLOW, imax(WREC, RLEN)) + 1);
  localparam int TA_W = $clog2(TA + 1);
  localparam int RC_W = $clog2(RECC + 1);

  ctrl_state_t st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;
  logic [TA_W-1:0]   ta_cnt;

  logic              ph_load, ph_zero, rc_load, rc_zero;
  logic [PH_W-1:0]   ph_val;
  logic              accept, done, rd_done;

  assign req_ready = (st == ST_IDLE) && !ret_req && !(req_write && (ta_cnt != '0));
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_nx   = st;
    ph_load = 1'b0;
    ph_val  = '0;
    rc_load = 1'b0;
    done    = 1'b0;
    rd_done = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ret_req) begin
          st_nx = ST_RET;
        end else if (accept) begin
          ph_load = 1'b1;
          if (req_write) begin
            st_nx  = ST_WR_ACT;
            ph_val = PH_W'(WLOW - 1);
          end else begin
            st_nx  = ST_RD;
            ph_val = PH_W'(RLEN - 1);
          end
        end
      end
      ST_WR_ACT: begin
        if (ph_zero) begin
          st_nx   = ST_WR_REC;
          ph_load = 1'b1;
          ph_val  = PH_W'(WREC - 1);
        end
      end
      ST_WR_REC: begin
        if (ph_zero) begin
          st_nx = ST_IDLE;
          done  = 1'b1;
        end
      end
      ST_RD: begin
        if (ph_zero) begin
          st_nx   = ST_IDLE;
          done    = 1'b1;
          rd_done = 1'b1;
        end
      end
      ST_RET: begin
        if (!ret_req) begin
          st_nx   = ST_RECOV;
          rc_load = 1'b1;
        end
      end
      ST_RECOV: begin
        if (ret_req)      st_nx = ST_RET;
        else if (rc_zero) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
      ta_cnt  <= '0;
    end else begin
      st    <= st_nx;
      rsp_q <= done;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_done) begin
        rdata_q <= mem_dq_i;
        ta_cnt  <= TA_W'(TA);
      end else if (st == ST_IDLE && ta_cnt != '0) begin
        ta_cnt  <= ta_cnt - 1'b1;
      end
    end
  end

  sram_phase_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  sram_phase_timer #(.W(RC_W)) u_recov (
    .clk(clk), .rst_n(rst_n), .load(rc_load), .load_val(RC_W'(RECC - 1)), .zero(rc_zero)
  );

  sram_pin_decode u_pins (
    .clk(clk), .rst_n(rst_n), .st(st),
    .cs1_n(mem_cs1_n), .cs2(mem_cs2), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && !$past(mem_cs1_n)) |-> $stable(mem_addr));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  ret_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && st == ST_IDLE) |=> (mem_cs1_n && !mem_cs2));

  // R10
  no_accept_in_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RET || st == ST_RECOV) |-> !req_ready);
endmodule

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
  localparam int CLK_NS = 10;
  localparam int WLOW = 6, WREC = 1, RLEN = 7, TA = 3, REC_NS = 200;
  localparam int RECC = (REC_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ret_req = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] mem_dq_o, mem_dq_i;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(.CLK_NS(CLK_NS), .T_REC_NS(REC_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  // memory model
  logic [7:0] mem [0:255];
  logic sel;
  assign sel = !mem_cs1_n && mem_cs2;
  always @(posedge clk) if (sel && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_o;
  assign mem_dq_i = (sel && !mem_oe_n) ? mem[mem_addr[7:0]] : 8'h00;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { bit rd; logic [7:0] data; } item_t;
  item_t q[$];
  logic [7:0] ref_mem [0:255];

  task automatic do_req(input bit w, input logic [16:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    it.rd = !w;
    if (w) begin ref_mem[a[7:0]] = d; it.data = d; end
    else it.data = ref_mem[a[7:0]];
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  int cyc = 0, we_cnt = 0, oe_cnt = 0, done_cyc = -100;
  bit prev_we = 1, prev_oe = 1, last_rd = 0, drv_ok = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R2 unexpected response", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(1, "R2", 1, 1);
          if (it.rd) chk(rsp_rdata == it.data, "R5 read data", rsp_rdata, it.data);
          last_rd = it.rd;
          done_cyc = cyc;
        end
      end
      if (!mem_we_n) begin
        we_cnt++;
        if (!(mem_dq_oe && mem_dq_o == ref_mem[mem_addr[7:0]])) drv_ok = 0;
      end
      if (prev_we && !mem_we_n && last_rd)
        chk(cyc - done_cyc >= TA + 1, "R7 read-to-write gap", cyc - done_cyc, TA + 1);
      if (prev_oe && !mem_oe_n && last_rd && done_cyc == cyc - 1)
        chk(1, "R7 read-after-read no gap", 1, 1);
      if (!prev_we && mem_we_n) begin
        chk(we_cnt == WLOW, "R3 WE low width", we_cnt, WLOW);
        chk(sel && !mem_dq_oe, "R3/R4 recovery: selected, bus released", {sel, mem_dq_oe}, 2);
        chk(drv_ok, "R4 data driven during WE low", drv_ok, 1);
        we_cnt = 0; drv_ok = 1;
      end
      if (!mem_oe_n) oe_cnt++;
      if (!prev_oe && mem_oe_n) begin
        chk(oe_cnt == RLEN, "R5 OE low width", oe_cnt, RLEN);
        oe_cnt = 0;
      end
      prev_we = mem_we_n;
      prev_oe = mem_oe_n;
    end
  end

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int k;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 pins in reset",
        {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(!rsp_valid, "R1 rsp low", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // writes then back-to-back reads
    do_req(1, 17'h1_0012, 8'h5A);
    do_req(1, 17'h0_0034, 8'hC3);
    do_req(1, 17'h0_00FF, 8'h01);
    do_req(1, 17'h1_FF80, 8'hFE);
    do_req(0, 17'h1_0012, 8'h00);
    do_req(0, 17'h0_0034, 8'h00);
    do_req(0, 17'h0_00FF, 8'h00);
    do_req(0, 17'h1_FF80, 8'h00);
    // read immediately followed by write (turnaround)
    do_req(1, 17'h0_0034, 8'h77);
    drain();
    // R8 idle state
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n, "R8 idle deselected",
        {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);

    // R11 hold of read data across a write
    do_req(0, 17'h0_0034, 8'h00);
    drain();
    held = rsp_rdata;
    do_req(1, 17'h0_0050, 8'h99);
    drain();
    chk(rsp_rdata == held && held == 8'h77, "R11 rdata held", rsp_rdata, 8'h77);

    // R9 retention while idle
    @(negedge clk);
    ret_req = 1; #1;
    chk(!req_ready, "R9 ready drops at once", req_ready, 0);
    repeat (5) @(negedge clk);
    chk(mem_cs1_n && !mem_cs2, "R9 deselected in retention", {mem_cs1_n, mem_cs2}, 2);
    @(negedge clk);
    ret_req = 0;
    k = 0; #1;
    while (!req_ready && k < 1000) begin @(negedge clk); #1; k++; end
    chk(k == RECC + 1, "R10 recovery hold-off", k, RECC + 1);

    // R9 retention arriving mid-write
    fork do_req(1, 17'h0_0060, 8'h3C); join_none
    @(negedge clk);
    while (mem_we_n) @(negedge clk);
    @(negedge clk);
    ret_req = 1;
    drain();
    chk(mem_cs1_n && !mem_cs2 && !req_ready, "R9 access finished then deselected",
        {mem_cs1_n, mem_cs2, req_ready}, 3'b100);
    repeat (4) @(negedge clk);
    ret_req = 0;
    do_req(0, 17'h0_0060, 8'h00);
    do_req(0, 17'h1_0012, 8'h00);
    drain();
    chk(q.size() == 0, "R2 all responses seen", q.size(), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule